// File: doc/BRIEF.md
# Iterative Feistel Round Cipher Engine

This block encrypts a 128-bit data word under a 128-bit key. It uses one shared round function for every round, so the area stays small. The data word is split into two 64-bit halves. Those halves are swapped on entry by wiring alone, and the round function then works on them for a parameterised number of rounds. On every round after the first, a pair of 64-bit multiplexers feeds the registered output of the previous round back into the round function. On the first round they take the freshly loaded input instead.

A key register rotates by a fixed amount after each round, which gives every round a different subkey without storing a table of round keys. A small sequencer sets the order of events:

- capture the input;
- run the rounds;
- latch each round result;
- undo the entry swap into a ciphertext register.

It then raises a one-cycle completion pulse.

The user drives `start` together with the data and key while the engine is idle, then waits for `done`. The ciphertext stays valid until the next accepted request completes.

Top module: `cfx_engine`

## Requirements
- R1: While reset is asserted and once it is released, `busy` and `done` are 0 and `ciphertext` is all zeros.
- R2: On entry the internal left half L takes `plaintext[63:0]` and the right half R takes `plaintext[127:64]`. After the last round the ciphertext is {R, L}, with R in bits 127:64.
- R3: Each round computes L' = R and R' = L xor P(S(E(R) xor K)), where K is the 96-bit round subkey.
- R4: E widens the 64-bit R into 96 bits. Nibble g (bits 4g+3..4g) becomes the 6-bit field at bits 6g+5..6g, laid out as {bit 4g+3, bits 4g+3..4g, bit 4g}.
- R5: S replaces each 6-bit field v (bits 6g+5..6g) with the 4-bit value ((7*v + 3) mod 16) xor {v[5:4], v[1:0]}, placed at bits 4g+3..4g.
- R6: P is the bit permutation in which output bit i equals input bit (13*i + 7) mod 64.
- R7: Rounds are numbered r = 0 .. NR-1. Round r uses bits 127:32 of the key rotated left by ROT*r bit positions.
- R8: `start` is ignored while `busy` is 1. The ongoing operation's result, its timing and the ciphertext are unaffected, and no extra operation follows.
- R9: `done` is a single-cycle pulse. It rises together with the ciphertext update, NR+1 clock edges after the edge that accepts `start`.
- R10: `ciphertext` keeps its value at all times except on the edge that raises `done`.
- R11: `busy` rises on the edge that accepts `start` and is 0 in the cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request an encryption; sampled only while idle |
| plaintext | input | 128 | Data word, captured when start is accepted |
| key | input | 128 | Cipher key, captured when start is accepted |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse marking a new ciphertext |
| ciphertext | output | 128 | Result of the last completed operation |

## Verification
Three groups of stimulus are used:

- **Walking one through the plaintext, key fixed.** All 128 positions are tried. Each one checks that every data bit reaches the output through the entry swap, the expansion, the S-box slices and the permutation in the right position. A misrouted bit changes only the runs that use it.
- **Walking one through the key, plaintext fixed.** All 128 positions are tried. This separates errors in the key rotation and in the choice of subkey slice from errors in the datapath.
- **Fixed patterns.** All-zero, all-one and alternating words cover the constant terms of the S-box.

A request raised repeatedly while the engine is busy shows that the engine neither queues nor restarts the work. Counting the edges to `done` pins down the latency.

// File: rtl/cfx_pkg.sv
package cfx_pkg;

  localparam int unsigned HALF_W  = 64;
  localparam int unsigned NIB_CNT = HALF_W / 4;
  localparam int unsigned EXP_W   = NIB_CNT * 6;
  localparam int unsigned BLK_W   = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [EXP_W-1:0]  subkey_t;
  typedef logic [BLK_W-1:0]  block_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;

  // 6-in, 4-out substitution, computed instead of tabulated
  function automatic logic [3:0] f_sub(input logic [5:0] v);
    logic [5:0] t;
    t = v * 6'd7 + 6'd3;
    return t[3:0] ^ {v[5:4], v[1:0]};
  endfunction

endpackage

// File: rtl/cfx_round.sv
module cfx_round
  import cfx_pkg::*;
(
  input  half_t   l_in,
  input  half_t   r_in,
  input  subkey_t subkey,
  output half_t   l_out,
  output half_t   r_out
);

  subkey_t wide;
  subkey_t mixed;
  half_t   subst;
  half_t   perm;

  // widening: each nibble gains copies of its edge bits
  for (genvar g = 0; g < NIB_CNT; g++) begin : g_exp
    assign wide[6*g+5]       = r_in[4*g+3];
    assign wide[6*g+4:6*g+1] = r_in[4*g+3:4*g];
    assign wide[6*g]         = r_in[4*g];
  end

  assign mixed = wide ^ subkey;

  for (genvar g = 0; g < NIB_CNT; g++) begin : g_sub
    assign subst[4*g+3:4*g] = f_sub(mixed[6*g+5:6*g]);
  end

  for (genvar i = 0; i < HALF_W; i++) begin : g_perm
    assign perm[i] = subst[(13*i+7) % HALF_W];
  end

  assign l_out = r_in;
  assign r_out = l_in ^ perm;

endmodule

// File: rtl/cfx_keysched.sv
module cfx_keysched
  import cfx_pkg::*;
#(
  parameter int unsigned ROT = 11
) (
  input  logic    clk,
  input  logic    rst_i,
  input  logic    load,
  input  logic    step,
  input  block_t  key_in,
  output subkey_t subkey
);

  block_t kreg_q;
  block_t kreg_d;
  block_t rotated;

  assign rotated = {kreg_q[BLK_W-1-ROT:0], kreg_q[BLK_W-1:BLK_W-ROT]};

  always_comb begin
    kreg_d = kreg_q;
    if (load)      kreg_d = key_in;
    else if (step) kreg_d = rotated;
  end

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) kreg_q <= '0;
    else       kreg_q <= kreg_d;
  end

  assign subkey = kreg_q[BLK_W-1:BLK_W-EXP_W];

endmodule

// File: rtl/cfx_ctrl.sv
module cfx_ctrl
  import cfx_pkg::*;
#(
  parameter int unsigned NR = 4
) (
  input  logic clk,
  input  logic rst_i,
  input  logic start,
  output logic ld_in,
  output logic sel_fb,
  output logic ld_out,
  output logic ld_ct,
  output logic busy
);

  localparam int unsigned CW = (NR > 1) ? $clog2(NR) : 1;
  localparam logic [CW-1:0] LAST = CW'(NR - 1);

  seq_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ld_in  = 1'b0;
    ld_out = 1'b0;
    ld_ct  = 1'b0;
    sel_fb = (cnt_q != '0);
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_in = 1'b1;
          cnt_d = '0;
          st_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        ld_out = 1'b1;
        if (cnt_q == LAST) st_d = ST_FIN;
        else               cnt_d = cnt_q + 1'b1;
      end
      ST_FIN: begin
        ld_ct = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/cfx_engine.sv
module cfx_engine
  import cfx_pkg::*;
#(
  parameter int unsigned NR  = 4,
  parameter int unsigned ROT = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] plaintext,
  input  logic [127:0] key,
  output logic         busy,
  output logic         done,
  output logic [127:0] ciphertext
);

  // reset: asserted at once, released after two clocks
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = ~rs_q[1];

  logic ld_in, sel_fb, ld_out, ld_ct;

  cfx_ctrl #(.NR(NR)) u_ctrl (
    .clk(clk), .rst_i(rst_i), .start(start),
    .ld_in(ld_in), .sel_fb(sel_fb), .ld_out(ld_out),
    .ld_ct(ld_ct), .busy(busy)
  );

  subkey_t sk;

  cfx_keysched #(.ROT(ROT)) u_ks (
    .clk(clk), .rst_i(rst_i), .load(ld_in), .step(ld_out),
    .key_in(key), .subkey(sk)
  );

  half_t in_l_q, in_r_q, in_l_d, in_r_d;
  half_t ov_l_q, ov_r_q, ov_l_d, ov_r_d;
  half_t cur_l, cur_r, nx_l, nx_r;
  block_t ct_q, ct_d;
  logic   done_q;

  // input register; entry swap is pure wiring
  always_comb begin
    in_l_d = in_l_q;
    in_r_d = in_r_q;
    if (ld_in) begin
      in_l_d = plaintext[HALF_W-1:0];
      in_r_d = plaintext[BLK_W-1:HALF_W];
    end
  end

  assign cur_l = sel_fb ? ov_l_q : in_l_q;
  assign cur_r = sel_fb ? ov_r_q : in_r_q;

  cfx_round u_rnd (
    .l_in(cur_l), .r_in(cur_r), .subkey(sk),
    .l_out(nx_l), .r_out(nx_r)
  );

  always_comb begin
    ov_l_d = ov_l_q;
    ov_r_d = ov_r_q;
    if (ld_out) begin
      ov_l_d = nx_l;
      ov_r_d = nx_r;
    end
  end

  // exit swap undoes the entry swap
  always_comb begin
    ct_d = ct_q;
    if (ld_ct) ct_d = {ov_r_q, ov_l_q};
  end

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) begin
      in_l_q <= '0;
      in_r_q <= '0;
      ov_l_q <= '0;
      ov_r_q <= '0;
      ct_q   <= '0;
      done_q <= 1'b0;
    end else begin
      in_l_q <= in_l_d;
      in_r_q <= in_r_d;
      ov_l_q <= ov_l_d;
      ov_r_q <= ov_r_d;
      ct_q   <= ct_d;
      done_q <= ld_ct;
    end
  end

  assign ciphertext = ct_q;
  assign done       = done_q;

endmodule

// File: rtl/cfx_checker.sv
module cfx_checker #(
  parameter int unsigned NR = 4
) (
  input logic         clk,
  input logic         rst_i,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] ciphertext
);

  localparam int unsigned LW = $clog2(NR + 3);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i)               lat_q <= '0;
    else if (start && !busy) lat_q <= '0;
    else if (busy)           lat_q <= lat_q + 1'b1;
  end

  // R9: pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst_i)
    done |=> !done);

  // R9 and R8: done arrives exactly NR+1 edges after acceptance
  p_done_latency_r9: assert property (@(posedge clk) disable iff (rst_i)
    done |-> (lat_q == LW'(NR + 1)));

  // R11: engine idle while done is shown
  p_idle_at_done_r11: assert property (@(posedge clk) disable iff (rst_i)
    done |-> !busy);

  // R11: accepted request raises busy
  p_accept_r11: assert property (@(posedge clk) disable iff (rst_i)
    (start && !busy) |=> busy);

  // R10: ciphertext moves only together with done
  p_ct_hold_r10: assert property (@(posedge clk) disable iff (rst_i)
    1'b1 |=> ($stable(ciphertext) || done));

endmodule

bind cfx_engine cfx_checker #(.NR(NR)) u_chk (
  .clk(clk), .rst_i(rst_i), .start(start), .busy(busy),
  .done(done), .ciphertext(ciphertext)
);

// File: tb/sim_cfx_engine.sv
module sim_cfx_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NR  = 4;
  localparam int ROT = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plaintext = '0;
  logic [127:0] key = '0;
  logic         busy, done;
  logic [127:0] ciphertext;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  cfx_engine #(.NR(NR), .ROT(ROT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
    .key(key), .busy(busy), .done(done), .ciphertext(ciphertext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, written from the requirement text
  function automatic logic [3:0] m_sub(input int v);
    int a, b;
    a = (7 * v + 3) % 16;
    b = ((v / 16) % 4) * 4 + (v % 4);
    return 4'(a ^ b);
  endfunction

  function automatic logic [63:0] m_f(input logic [63:0] r, input logic [95:0] k);
    logic [95:0] e;
    logic [63:0] s, p;
    for (int g = 0; g < 16; g++) begin
      e[6*g]   = r[4*g];
      for (int b = 0; b < 4; b++) e[6*g+1+b] = r[4*g+b];
      e[6*g+5] = r[4*g+3];
    end
    e = e ^ k;
    for (int g = 0; g < 16; g++) begin
      int v = 0;
      for (int b = 0; b < 6; b++) if (e[6*g+b]) v += (1 << b);
      s[4*g +: 4] = m_sub(v);
    end
    for (int i = 0; i < 64; i++) p[i] = s[(13*i+7) % 64];
    return p;
  endfunction

  function automatic logic [127:0] m_cipher(input logic [127:0] pt, input logic [127:0] k);
    logic [63:0] l, r, t;
    logic [127:0] kr;
    l = pt[63:0];
    r = pt[127:64];
    for (int rd = 0; rd < NR; rd++) begin
      int n = (ROT * rd) % 128;
      kr = (n == 0) ? k : ((k << n) | (k >> (128 - n)));
      t = l ^ m_f(r, kr[127:32]);
      l = r;
      r = t;
    end
    return {r, l};
  endfunction

  // one request; extra = number of later cycles to re-raise start while busy
  task automatic run_op(input logic [127:0] pt, input logic [127:0] k,
                        input int extra, input string tag);
    int n;
    logic [127:0] exp;
    exp = m_cipher(pt, k);
    @(negedge clk);
    plaintext = pt;
    key = k;
    start = 1'b1;
    @(negedge clk);
    n = 1;
    chk("R11 busy after accept", 128'(busy), 128'(1));
    if (extra > 0) begin
      plaintext = ~pt;
      key = ~k;
    end else begin
      start = 1'b0;
    end
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (n > extra) start = 1'b0;
    end
    start = 1'b0;
    chk("R9 latency", 128'(n), 128'(NR + 2));
    chk(tag, ciphertext, exp);
    chk("R11 idle at done", 128'(busy), 128'(0));
  endtask

  initial begin
    logic [127:0] hold;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 128'(busy), 128'(0));
    chk("R1 done in reset", 128'(done), 128'(0));
    chk("R1 ct in reset", ciphertext, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ct after release", ciphertext, '0);
    chk("R1 busy after release", 128'(busy), 128'(0));

    // fixed patterns: S-box constants (R5) and swap (R2)
    run_op('0, '0, 0, "R2/R5 zero word");
    run_op('1, '1, 0, "R2/R5 ones word");
    run_op({64{2'b10}}, {64{2'b01}}, 0, "R3/R4 alternating");
    run_op(128'h0123456789abcdeffedcba9876543210,
           128'h00112233445566778899aabbccddeeff, 0, "R3/R6 mixed");

    // walking one through the data word: R2 R3 R4 R5 R6
    for (int b = 0; b < 128; b++)
      run_op(128'(1) << b, 128'h5a5a_0f0f_3c3c_9696_a5a5_f0f0_c3c3_6969, 0,
             "R2/R3/R4/R5/R6 walking data bit");

    // walking one through the key: R7
    for (int b = 0; b < 128; b++)
      run_op(128'hdeadbeef_cafef00d_12345678_9abcdef0, 128'(1) << b, 0,
             "R7 walking key bit");

    // R8: requests raised while busy must be ignored
    run_op(128'h1111_2222_3333_4444_5555_6666_7777_8888,
           128'h9999_aaaa_bbbb_cccc_dddd_eeee_ffff_0000, 3, "R8 start while busy");
    hold = ciphertext;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) n++;
    end
    chk("R8 no queued operation", 128'(n), 128'(0));
    chk("R10 ciphertext held", ciphertext, hold);
    chk("R11 idle afterwards", 128'(busy), 128'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule